// File: doc/BRIEF.md
# Test access port controller

This block is the sequencing engine for a serial test port. A single mode-select input, sampled on every rising edge of the test clock, walks a fixed sixteen-state graph. The graph has a reset state, an idle state and two parallel branches of seven states each. One branch drives the data-register path and the other drives the instruction path. Each branch has a select, capture, shift, first exit, pause, second exit and update state.

From the current state the block decodes the strobes that the surrounding test logic needs. These are capture and shift enables for each path, update strobes for each path, a path select that is high while the instruction branch is active, and a reset flag. Instruction decoding and the contents of the registers belong to the logic around the block.

An optional active-low test reset forces the graph back to its reset state. It can be asynchronous or sampled on the test clock, chosen by a parameter. Without that pin, five clocks with mode-select high reach the reset state from anywhere. The update strobes can be limited to the low phase of the test clock in the update state, or they can cover the whole update cycle. A parameter chooses between the two.

Top module: `tstctl`

## Requirements
- R1: While `test_rst_n` is low, `state_code` is 0 (the reset state). In the default asynchronous mode this takes effect without waiting for a clock edge.
- R2: `state_code` changes only on a rising `test_clk` edge. It uses this encoding: 0 reset, 1 idle, 2..8 data branch (select, capture, shift, exit1, pause, exit2, update), 9..15 instruction branch in the same order.
- R3: In state 0, a low mode-select moves to state 1 and a high one stays in state 0.
- R4: From idle, mode-select 1,1,0,0 reaches instruction shift (11) and 1,0,0 reaches data shift (4).
- R5: Five consecutive rising edges with mode-select high leave `state_code` at 0 from any starting state.
- R6: With mode-select low, idle, both shift states and both pause states hold.
- R7: `state_onehot` has exactly one bit set, at index `state_code`.
- R8: `cap_dr`, `shf_dr`, `cap_ir` and `shf_ir` are high exactly in states 3, 4, 10 and 11 respectively.
- R9: `upd_dr` and `upd_ir` are high only in states 8 and 15 respectively. With the default gating they are high in the low phase of `test_clk` only.
- R10: `path_ir` is high exactly in states 9 to 15.
- R11: `in_reset` is high exactly in state 0.
- R12: Exit2 with mode-select low returns to its shift state. Update goes to data select (2) on high and to idle (1) on low. Instruction select with high goes to state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock; the state advances on its rising edge |
| test_rst_n | input | 1 | Active-low test reset |
| mode_sel | input | 1 | Mode-select input that steers the state graph |
| state_code | output | 4 | Encoded current state |
| state_onehot | output | 16 | One-hot copy of the current state |
| in_reset | output | 1 | High in the reset state |
| path_ir | output | 1 | Selects the instruction path, high in states 9..15 |
| cap_dr | output | 1 | Data-path capture enable |
| shf_dr | output | 1 | Data-path shift enable |
| upd_dr | output | 1 | Data-path update strobe |
| cap_ir | output | 1 | Instruction-path capture enable |
| shf_ir | output | 1 | Instruction-path shift enable |
| upd_ir | output | 1 | Instruction-path update strobe |

## Verification
On every cycle the assertions check the following: the one-hot output agrees with the code, the enables and strobes appear only in their own states, the shift state holds under a low mode-select, and the reset state is entered after a low test reset and after five high samples, counted in the checker. The full transition table is shown only by the bench scenarios. A reference model walks random mode-select streams and compares every output after every edge. Directed runs add the named routes into both shift states, the pause and exit2 loops, and the release from update. They also cover the low-phase timing of the update strobes and an asynchronous reset applied in the middle of a cycle.

// File: rtl/tstctl_pkg.sv
package tstctl_pkg;

   localparam int ST_W = 4;
   localparam int N_ST = 16;
   localparam int BR_LEN = 7;

   typedef logic [ST_W-1:0] st_t;

   localparam st_t S_RESET  = 4'd0;
   localparam st_t S_IDLE   = 4'd1;
   localparam st_t S_SEL_DR = 4'd2;
   localparam st_t S_SEL_IR = 4'd9;

   localparam st_t OFF_SEL = 4'd0;
   localparam st_t OFF_CAP = 4'd1;
   localparam st_t OFF_SHF = 4'd2;
   localparam st_t OFF_EX1 = 4'd3;
   localparam st_t OFF_PAU = 4'd4;
   localparam st_t OFF_EX2 = 4'd5;
   localparam st_t OFF_UPD = 4'd6;

endpackage

// File: rtl/tstctl_step.sv
module tstctl_step
   import tstctl_pkg::*;
(
   input  st_t  st_i,
   input  logic m_i,
   output st_t  nxt_o
);

   logic is_ir;
   st_t  base;
   st_t  rel;

   always_comb begin
      is_ir = (st_i >= S_SEL_IR);
      base  = is_ir ? S_SEL_IR : S_SEL_DR;
      rel   = st_i - base;
      nxt_o = st_i;
      if (st_i == S_RESET) begin
         nxt_o = m_i ? S_RESET : S_IDLE;
      end else if (st_i == S_IDLE) begin
         nxt_o = m_i ? S_SEL_DR : S_IDLE;
      end else begin
         case (rel)
            OFF_SEL: nxt_o = m_i ? (is_ir ? S_RESET : S_SEL_IR) : base + OFF_CAP;
            OFF_CAP: nxt_o = m_i ? base + OFF_EX1 : base + OFF_SHF;
            OFF_SHF: nxt_o = m_i ? base + OFF_EX1 : base + OFF_SHF;
            OFF_EX1: nxt_o = m_i ? base + OFF_UPD : base + OFF_PAU;
            OFF_PAU: nxt_o = m_i ? base + OFF_EX2 : base + OFF_PAU;
            OFF_EX2: nxt_o = m_i ? base + OFF_UPD : base + OFF_SHF;
            OFF_UPD: nxt_o = m_i ? S_SEL_DR : S_IDLE;
            default: nxt_o = S_RESET;
         endcase
      end
   end

endmodule

// File: rtl/tstctl_streg.sv
module tstctl_streg
   import tstctl_pkg::*;
#(
   parameter int RST_MODE = 0
)(
   input  logic clk,
   input  logic rst_n,
   input  st_t  nxt_i,
   output st_t  st_o
);

   if (!(RST_MODE inside {0, 1})) begin : g_bad_mode
      $error("tstctl_streg: RST_MODE must be 0 or 1");
   end

   if (RST_MODE == 0) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_o <= S_RESET;
         else        st_o <= nxt_i;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) st_o <= S_RESET;
         else        st_o <= nxt_i;
      end
   end

endmodule

// File: rtl/tstctl_decode.sv
module tstctl_decode
   import tstctl_pkg::*;
(
   input  st_t        st_i,
   output logic [1:0] cap_o,
   output logic [1:0] shf_o,
   output logic [1:0] upd_st_o,
   output logic       path_ir_o,
   output logic       in_reset_o
);

   for (genvar b = 0; b < 2; b++) begin : g_branch
      localparam int BASE = 2 + BR_LEN * b;
      assign cap_o[b]    = (st_i == st_t'(BASE + 1));
      assign shf_o[b]    = (st_i == st_t'(BASE + 2));
      assign upd_st_o[b] = (st_i == st_t'(BASE + 6));
   end

   assign path_ir_o  = (st_i >= S_SEL_IR);
   assign in_reset_o = (st_i == S_RESET);

endmodule

// File: rtl/tstctl_strobe.sv
module tstctl_strobe #(
   parameter int UPD_GATE = 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic upd_st_i,
   output logic upd_o
);

   if (!(UPD_GATE inside {0, 1})) begin : g_bad_gate
      $error("tstctl_strobe: UPD_GATE must be 0 or 1");
   end

   if (UPD_GATE == 1) begin : g_low_phase
      logic fall_q;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) fall_q <= 1'b0;
         else        fall_q <= upd_st_i;
      end
      assign upd_o = fall_q & upd_st_i;
   end else begin : g_full_cycle
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign upd_o      = upd_st_i;
   end

endmodule

// File: rtl/tstctl.sv
module tstctl
   import tstctl_pkg::*;
#(
   parameter int RST_MODE = 0,
   parameter int UPD_GATE = 1
)(
   input  logic                test_clk,
   input  logic                test_rst_n,
   input  logic                mode_sel,
   output logic [ST_W-1:0]     state_code,
   output logic [N_ST-1:0]     state_onehot,
   output logic                in_reset,
   output logic                path_ir,
   output logic                cap_dr,
   output logic                shf_dr,
   output logic                upd_dr,
   output logic                cap_ir,
   output logic                shf_ir,
   output logic                upd_ir
);

   if ((1 << ST_W) < N_ST) begin : g_bad_width
      $error("tstctl: state code too narrow for the state count");
   end

   st_t        st_q;
   st_t        st_nxt;
   logic [1:0] cap_w;
   logic [1:0] shf_w;
   logic [1:0] upd_st_w;
   logic [1:0] upd_w;

   tstctl_step u_step (
      .st_i  (st_q),
      .m_i   (mode_sel),
      .nxt_o (st_nxt)
   );

   tstctl_streg #(.RST_MODE(RST_MODE)) u_streg (
      .clk   (test_clk),
      .rst_n (test_rst_n),
      .nxt_i (st_nxt),
      .st_o  (st_q)
   );

   tstctl_decode u_dec (
      .st_i       (st_q),
      .cap_o      (cap_w),
      .shf_o      (shf_w),
      .upd_st_o   (upd_st_w),
      .path_ir_o  (path_ir),
      .in_reset_o (in_reset)
   );

   for (genvar b = 0; b < 2; b++) begin : g_upd
      tstctl_strobe #(.UPD_GATE(UPD_GATE)) u_strobe (
         .clk      (test_clk),
         .rst_n    (test_rst_n),
         .upd_st_i (upd_st_w[b]),
         .upd_o    (upd_w[b])
      );
   end

   for (genvar i = 0; i < N_ST; i++) begin : g_onehot
      assign state_onehot[i] = (st_q == st_t'(i));
   end

   assign state_code = st_q;
   assign cap_dr     = cap_w[0];
   assign shf_dr     = shf_w[0];
   assign upd_dr     = upd_w[0];
   assign cap_ir     = cap_w[1];
   assign shf_ir     = shf_w[1];
   assign upd_ir     = upd_w[1];

endmodule

// File: rtl/tstctl_chk.sv
module tstctl_chk
   import tstctl_pkg::*;
(
   input logic            test_clk,
   input logic            test_rst_n,
   input logic            mode_sel,
   input logic [ST_W-1:0] state_code,
   input logic [N_ST-1:0] state_onehot,
   input logic            in_reset,
   input logic            path_ir,
   input logic            cap_dr,
   input logic            shf_dr,
   input logic            upd_dr,
   input logic            cap_ir,
   input logic            shf_ir,
   input logic            upd_ir
);

   logic [2:0] high_run;

   always_ff @(posedge test_clk or negedge test_rst_n) begin
      if (!test_rst_n)       high_run <= 3'd0;
      else if (!mode_sel)    high_run <= 3'd0;
      else if (high_run < 3'd7) high_run <= high_run + 3'd1;
   end

   p_reset_r1: assert property (@(posedge test_clk)
      !test_rst_n |=> state_code == 4'd0);

   p_idle_entry_r3: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      (state_code == 4'd0 && !mode_sel) |=> state_code == 4'd1);

   p_five_high_r5: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      high_run >= 3'd5 |-> state_code == 4'd0);

   p_shift_hold_r6: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      (state_code == 4'd4 && !mode_sel) |=> state_code == 4'd4);

   p_onehot_r7: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      $countones(state_onehot) == 1 && state_onehot[state_code]);

   p_enables_r8: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      $onehot0({cap_dr, shf_dr, cap_ir, shf_ir}) &&
      (!shf_ir || state_onehot[11]) && (!cap_dr || state_onehot[3]));

   p_update_r9: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      (!upd_dr || state_onehot[8]) && (!upd_ir || state_onehot[15]));

   p_path_r10: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      (cap_ir || shf_ir || upd_ir) |-> path_ir);

   p_flag_r11: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      in_reset |-> !path_ir && state_onehot[0]);

endmodule

bind tstctl tstctl_chk u_chk (
   .test_clk     (test_clk),
   .test_rst_n   (test_rst_n),
   .mode_sel     (mode_sel),
   .state_code   (state_code),
   .state_onehot (state_onehot),
   .in_reset     (in_reset),
   .path_ir      (path_ir),
   .cap_dr       (cap_dr),
   .shf_dr       (shf_dr),
   .upd_dr       (upd_dr),
   .cap_ir       (cap_ir),
   .shf_ir       (shf_ir),
   .upd_ir       (upd_ir)
);

// File: tb/tstctl_bench.sv
`timescale 1ns/1ps
module tstctl_bench;

   logic        test_clk = 1'b0;
   logic        test_rst_n;
   logic        mode_sel;
   logic [3:0]  state_code;
   logic [15:0] state_onehot;
   logic        in_reset, path_ir, cap_dr, shf_dr, upd_dr, cap_ir, shf_ir, upd_ir;

   int checks = 0;
   int failures = 0;
   logic [3:0] ref_st = 4'd0;

   always #4 test_clk = ~test_clk;

   tstctl u_tstctl (
      .test_clk     (test_clk),
      .test_rst_n   (test_rst_n),
      .mode_sel     (mode_sel),
      .state_code   (state_code),
      .state_onehot (state_onehot),
      .in_reset     (in_reset),
      .path_ir      (path_ir),
      .cap_dr       (cap_dr),
      .shf_dr       (shf_dr),
      .upd_dr       (upd_dr),
      .cap_ir       (cap_ir),
      .shf_ir       (shf_ir),
      .upd_ir       (upd_ir)
   );

   function automatic logic [3:0] ref_next(input logic [3:0] s, input bit m);
      case (s)
         4'd0:  return m ? 4'd0  : 4'd1;
         4'd1:  return m ? 4'd2  : 4'd1;
         4'd2:  return m ? 4'd9  : 4'd3;
         4'd3:  return m ? 4'd5  : 4'd4;
         4'd4:  return m ? 4'd5  : 4'd4;
         4'd5:  return m ? 4'd8  : 4'd6;
         4'd6:  return m ? 4'd7  : 4'd6;
         4'd7:  return m ? 4'd8  : 4'd4;
         4'd8:  return m ? 4'd2  : 4'd1;
         4'd9:  return m ? 4'd0  : 4'd10;
         4'd10: return m ? 4'd12 : 4'd11;
         4'd11: return m ? 4'd12 : 4'd11;
         4'd12: return m ? 4'd15 : 4'd13;
         4'd13: return m ? 4'd14 : 4'd13;
         4'd14: return m ? 4'd15 : 4'd11;
         default: return m ? 4'd2 : 4'd1;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(state_code == ref_st, "R2 state", state_code, ref_st);
      chk(state_onehot == (16'd1 << ref_st), "R7 onehot", state_onehot, 16'd1 << ref_st);
      chk(in_reset == (ref_st == 4'd0), "R11 in_reset", in_reset, ref_st == 4'd0);
      chk(path_ir == (ref_st >= 4'd9), "R10 path", path_ir, ref_st >= 4'd9);
      chk({cap_dr, shf_dr, cap_ir, shf_ir} ==
          {ref_st == 4'd3, ref_st == 4'd4, ref_st == 4'd10, ref_st == 4'd11},
          "R8 enables", {cap_dr, shf_dr, cap_ir, shf_ir},
          {ref_st == 4'd3, ref_st == 4'd4, ref_st == 4'd10, ref_st == 4'd11});
      chk({upd_dr, upd_ir} == {ref_st == 4'd8, ref_st == 4'd15}, "R9 low phase",
          {upd_dr, upd_ir}, {ref_st == 4'd8, ref_st == 4'd15});
   endtask

   // one rising edge; outputs checked in high half (strobes) and low half (all)
   task automatic step(input bit m);
      mode_sel = m;
      @(posedge test_clk);
      ref_st = ref_next(ref_st, m);
      #2;
      chk({upd_dr, upd_ir} == 2'b00, "R9 high phase", {upd_dr, upd_ir}, 0);
      #4;
      compare_all();
   endtask

   task automatic walk_to(input logic [3:0] target);
      int guard = 0;
      while (ref_st != target && guard < 40) begin
         step($urandom_range(0, 1) == 1);
         guard++;
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
   end

   initial begin
      void'($urandom(32'd20241));
      test_rst_n = 1'b0;
      mode_sel   = 1'b1;
      repeat (2) @(posedge test_clk);
      #6;
      ref_st = 4'd0;
      chk(state_code == 4'd0, "R1 reset state", state_code, 0);
      compare_all();
      test_rst_n = 1'b1;

      // R3: high holds reset, low reaches idle
      step(1'b1);
      chk(state_code == 4'd0, "R3 hold", state_code, 0);
      step(1'b0);
      chk(state_code == 4'd1, "R3 to idle", state_code, 1);
      step(1'b0);
      chk(state_code == 4'd1, "R6 idle hold", state_code, 1);

      // R4: route to instruction shift
      step(1'b1); step(1'b1); step(1'b0); step(1'b0);
      chk(state_code == 4'd11, "R4 shift-ir", state_code, 11);
      step(1'b0);
      chk(state_code == 4'd11, "R6 shift-ir hold", state_code, 11);
      // exit1, pause hold, exit2, back to shift
      step(1'b1); step(1'b0); step(1'b0);
      chk(state_code == 4'd13, "R6 pause-ir hold", state_code, 13);
      step(1'b1); step(1'b0);
      chk(state_code == 4'd11, "R12 exit2 to shift", state_code, 11);
      // exit1, update, then high to data select
      step(1'b1); step(1'b1);
      chk(upd_ir == 1'b1, "R9 update-ir strobe", upd_ir, 1);
      step(1'b1);
      chk(state_code == 4'd2, "R12 update to select", state_code, 2);
      // capture-dr then shift-dr
      step(1'b0); step(1'b0);
      chk(state_code == 4'd4, "R4 shift-dr via select", state_code, 4);
      step(1'b1); step(1'b1);
      chk(upd_dr == 1'b1, "R9 update-dr strobe", upd_dr, 1);
      step(1'b0);
      chk(state_code == 4'd1, "R12 update to idle", state_code, 1);
      step(1'b1); step(1'b0); step(1'b0);
      chk(state_code == 4'd4, "R4 shift-dr", state_code, 4);
      // select-ir with high returns to reset
      step(1'b1); step(1'b1); step(1'b1); step(1'b1);
      chk(state_code == 4'd9, "R12 at select-ir", state_code, 9);
      step(1'b1);
      chk(state_code == 4'd0, "R12 select-ir escape", state_code, 0);

      // R5: five highs from each reachable state
      for (int t = 1; t < 16; t++) begin
         step(1'b0);
         walk_to(4'(t));
         for (int k = 0; k < 5; k++) step(1'b1);
         chk(state_code == 4'd0, "R5 five highs", state_code, 0);
      end

      // constrained random walk with mid-cycle async resets
      for (int n = 0; n < 1500; n++) begin
         if ((n % 211) == 150) begin
            #1;
            test_rst_n = 1'b0;
            #1;
            ref_st = 4'd0;
            chk(state_code == 4'd0, "R1 async reset", state_code, 0);
            mode_sel = 1'b0;
            @(posedge test_clk);
            #6;
            chk(state_code == 4'd0, "R1 reset held", state_code, 0);
            test_rst_n = 1'b1;
         end else begin
            step($urandom_range(0, 99) < 45);
         end
      end

      report();
   end

endmodule